// File: doc/BRIEF.md
# Serial Configuration Register Write Port

This block is a write-only slave on a three-wire serial link: an active-low select, a serial clock and a serial data line. It sits inside a small display controller. It turns 16-bit serial words into updates of a handful of control flags, and those flags steer the panel's scan direction, input data format, driver standby, timing variant and horizontal input delay. The three serial inputs are asynchronous to the system clock. They are first passed through two-flop synchronizers, and all frame handling then runs on the system clock.

Each frame is shifted in most significant bit first. The top five bits pick a target register and the low bits carry its value. A frame takes effect only when the select line is released after exactly sixteen clock pulses. Frames with an unknown address do nothing. Frames to the register whose bits are all fixed levels also do nothing. Writing zero to the soft-reset flag returns every control flag to its power-up value. The active-low reset input does the same.

Top module: `serialCfgPort`

## Requirements
- R1: While `rstN` is low, and after it is released, the outputs hold their defaults: `vScanDown`=1, `hScanReverse`=0, `wideData`=0, `driverActive`=1, `wideTiming`=0, `hDelay`=00. Asserting `rstN` at any time restores these defaults.
- R2: A frame is 16 bits sampled on rising `sclk` edges while `csN` is low, most significant bit first. Bits 15..11 form the address and bits 10..0 are data.
- R3: A frame with address 00000 loads data bit 0 into `vScanDown` (1 = top to bottom) and data bit 1 into `hScanReverse` (1 = right to left).
- R4: Address 00100 loads data bit 0 into `wideData`. Address 01100 loads data bit 0 into `wideTiming` (0 = narrow, 1 = wide).
- R5: Address 01000 with data bit 3 = 1 loads data bit 2 into `driverActive`, where 0 means standby.
- R6: Address 01000 with data bit 3 = 0 returns every output to its R1 default, whatever data bit 2 holds.
- R7: Address 10100 loads data bits 1..0 into `hDelay`.
- R8: A frame is applied on the rising edge of `csN` only if exactly 16 `sclk` rising edges were seen. A frame of 15 or 17 bits changes no output.
- R9: Frames to an undefined address (such as 00001 or 11000) change no output. Frames to address 10000, whose bits are all fixed levels, also change no output.
- R10: `csN`, `sclk` and `sdata` each pass through two synchronizer flops. An accepted frame changes the outputs on the third rising `clk` edge after `csN` goes high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset to defaults |
| csN | input | 1 | Serial select, active low; its rising edge ends a frame |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| vScanDown | output | 1 | Vertical scan: 1 top to bottom |
| hScanReverse | output | 1 | Horizontal scan: 1 right to left |
| wideData | output | 1 | Input data format for the wide timing |
| driverActive | output | 1 | 1 normal operation, 0 standby |
| wideTiming | output | 1 | Timing variant: 0 narrow, 1 wide |
| hDelay | output | 2 | Horizontal input delay code |

## Verification
Outputs move only when `csN` rises. They move on the third rising clock edge after that, one edge for each of the two synchronizer stages and one for edge detection plus the register load. One scenario samples at falling clock edges: two falling edges after the release it expects the old values, and one edge later it expects the new ones. Every other scenario waits more than a hundred cycles after the release before it compares all seven output bits against a model the bench keeps itself. Frames that must be ignored are checked the same way, against the unchanged model.

// File: rtl/cfgPkg.sv
package cfgPkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADDR_SCAN = 5'b00000;
  localparam logic [ADDR_W-1:0] ADDR_FMT  = 5'b00100;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'b01000;
  localparam logic [ADDR_W-1:0] ADDR_TIME = 5'b01100;
  localparam logic [ADDR_W-1:0] ADDR_FIXD = 5'b10000;
  localparam logic [ADDR_W-1:0] ADDR_HDLY = 5'b10100;

  typedef struct packed {
    logic shiftEn;
    logic commit;
  } cfgStrobe_t;

  typedef struct packed {
    logic       vScanDown;
    logic       hScanReverse;
    logic       wideData;
    logic       driverActive;
    logic       wideTiming;
    logic [1:0] hDelay;
  } cfgState_t;

  localparam cfgState_t CFG_DEFAULT = '{
    vScanDown:    1'b1,
    hScanReverse: 1'b0,
    wideData:     1'b0,
    driverActive: 1'b1,
    wideTiming:   1'b0,
    hDelay:       2'b00
  };

endpackage

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgPkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdata,
  output cfgStrobe_t strb,
  output logic       dataBit
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] csSh, sclkSh, sdaSh;
  logic csS, sclkS, sdaS;
  logic csPrev, sclkPrev;
  logic csRise, sclkRise;
  logic [CNT_W-1:0] bitCnt;

  // synchronizer chains, first stage at index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSh   <= '1;
      sclkSh <= '0;
      sdaSh  <= '0;
    end else begin
      csSh[0]   <= csN;
      sclkSh[0] <= sclk;
      sdaSh[0]  <= sdata;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        csSh[i]   <= csSh[i-1];
        sclkSh[i] <= sclkSh[i-1];
        sdaSh[i]  <= sdaSh[i-1];
      end
    end
  end

  assign csS   = csSh[SYNC_STAGES-1];
  assign sclkS = sclkSh[SYNC_STAGES-1];
  assign sdaS  = sdaSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csRise   = csS & ~csPrev;
  assign sclkRise = sclkS & ~sclkPrev;

  // bit counter saturates one past a full frame so overlong frames are seen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (csS)
      bitCnt <= '0;
    else if (sclkRise && bitCnt != CNT_MAX)
      bitCnt <= bitCnt + 1'b1;
  end

  assign strb.shiftEn = sclkRise & ~csS;
  assign strb.commit  = csRise & (bitCnt == CNT_FULL);
  assign dataBit      = sdaS;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_MAX); // R8

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0)); // R8

  AST_COMMIT_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (csS && !strb.shiftEn)); // R8

endmodule

// File: rtl/cfgRegs.sv
module cfgRegs
  import cfgPkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strb,
  input  logic       dataBit,
  output cfgState_t  cfg
);

  localparam int DATA_W = FRAME_BITS - ADDR_W;

  logic [FRAME_BITS-1:0] shiftR;
  logic [ADDR_W-1:0]     addr;
  logic [DATA_W-1:0]     data;
  cfgState_t             cfgNext;
  logic                  unusedData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftR <= '0;
    else if (strb.shiftEn)
      shiftR <= {shiftR[FRAME_BITS-2:0], dataBit};
  end

  assign addr       = shiftR[FRAME_BITS-1 -: ADDR_W];
  assign data       = shiftR[DATA_W-1:0];
  assign unusedData = ^data[DATA_W-1:4];

  always_comb begin
    cfgNext = cfg;
    if (strb.commit) begin
      case (addr)
        ADDR_SCAN: begin
          cfgNext.vScanDown    = data[0];
          cfgNext.hScanReverse = data[1];
        end
        ADDR_FMT:  cfgNext.wideData = data[0];
        ADDR_CTRL: begin
          if (!data[3])
            cfgNext = CFG_DEFAULT;
          else
            cfgNext.driverActive = data[2];
        end
        ADDR_TIME: cfgNext.wideTiming = data[0];
        ADDR_HDLY: cfgNext.hDelay     = data[1:0];
        default:   cfgNext = cfg;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfg <= CFG_DEFAULT;
    else
      cfg <= cfgNext;
  end

  logic addrLive;
  assign addrLive = (addr == ADDR_SCAN) || (addr == ADDR_FMT) ||
                    (addr == ADDR_CTRL) || (addr == ADDR_TIME) ||
                    (addr == ADDR_HDLY);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(cfg)); // R8

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && addr == ADDR_CTRL && !shiftR[3]) |=> (cfg == CFG_DEFAULT)); // R6

  AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && (!addrLive || addr == ADDR_FIXD)) |=> $stable(cfg)); // R9

  AST_HDLY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && addr == ADDR_HDLY) |=> (cfg.hDelay == $past(shiftR[1:0]))); // R7

endmodule

// File: rtl/serialCfgPort.sv
module serialCfgPort
  import cfgPkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdata,
  output logic       vScanDown,
  output logic       hScanReverse,
  output logic       wideData,
  output logic       driverActive,
  output logic       wideTiming,
  output logic [1:0] hDelay
);

  cfgStrobe_t strb;
  logic       dataBit;
  cfgState_t  cfg;

  cfgCtrl #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) i_cfgCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclk    (sclk),
    .sdata   (sdata),
    .strb    (strb),
    .dataBit (dataBit)
  );

  cfgRegs #(.FRAME_BITS(FRAME_BITS)) i_cfgRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataBit (dataBit),
    .cfg     (cfg)
  );

  assign vScanDown    = cfg.vScanDown;
  assign hScanReverse = cfg.hScanReverse;
  assign wideData     = cfg.wideData;
  assign driverActive = cfg.driverActive;
  assign wideTiming   = cfg.wideTiming;
  assign hDelay       = cfg.hDelay;

endmodule

// File: tb/test_serialCfgPort.sv
`timescale 1ns/1ps
module test_serialCfgPort;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic vScanDown, hScanReverse, wideData, driverActive, wideTiming;
  logic [1:0] hDelay;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  // {vScanDown, hScanReverse, wideData, driverActive, wideTiming, hDelay}
  logic [6:0] expCfg;
  localparam logic [6:0] DEF_CFG = 7'b1001000;

  always #5 clk = ~clk;

  serialCfgPort i_serialCfgPort (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdata(sdata),
    .vScanDown(vScanDown), .hScanReverse(hScanReverse), .wideData(wideData),
    .driverActive(driverActive), .wideTiming(wideTiming), .hDelay(hDelay)
  );

  function automatic logic [6:0] actCfg();
    return {vScanDown, hScanReverse, wideData, driverActive, wideTiming, hDelay};
  endfunction

  task automatic checkCfg(input string req, input logic [6:0] exp);
    checks++;
    if (actCfg() !== exp) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b", req, actCfg(), exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // settle=0 returns right after csN is driven high at a falling clk edge
  task automatic sendFrame(input logic [15:0] w, input int nbits, input bit settle);
    @(negedge clk);
    csN = 1'b0;
    waitClk(16);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[15-i] : 1'b0;
      waitClk(16);
      sclk = 1'b1;
      waitClk(16);
      sclk = 1'b0;
    end
    waitClk(16);
    csN = 1'b1;
    if (settle) waitClk(120);
  endtask

  task automatic testReset();
    expCfg = DEF_CFG;
    checkCfg("R1 defaults after reset", expCfg);
  endtask

  task automatic testScan();
    sendFrame(16'h0002, 16, 1);
    expCfg = 7'b0101000;
    checkCfg("R3 R2 scan bits 10", expCfg);
    sendFrame(16'h0001, 16, 1);
    expCfg = 7'b1001000;
    checkCfg("R3 R2 scan bits 01", expCfg);
  endtask

  task automatic testFormat();
    sendFrame(16'h2001, 16, 1);
    expCfg = 7'b1011000;
    checkCfg("R4 wide data format", expCfg);
    sendFrame(16'h6001, 16, 1);
    expCfg = 7'b1011100;
    checkCfg("R4 wide timing", expCfg);
  endtask

  task automatic testDelay();
    sendFrame(16'hA003, 16, 1);
    expCfg = 7'b1011111;
    checkCfg("R7 hDelay 11", expCfg);
  endtask

  task automatic testLatency();
    sendFrame(16'hA002, 16, 0);
    waitClk(2);
    checkCfg("R10 no change two edges after release", expCfg);
    waitClk(1);
    expCfg = 7'b1011110;
    checkCfg("R10 change on third edge, R7 hDelay 10", expCfg);
    waitClk(120);
  endtask

  task automatic testStandby();
    sendFrame(16'h4008, 16, 1);
    expCfg = 7'b1010110;
    checkCfg("R5 standby", expCfg);
    sendFrame(16'h400C, 16, 1);
    expCfg = 7'b1011110;
    checkCfg("R5 normal operation", expCfg);
  endtask

  task automatic testBadCount();
    sendFrame(16'h0002, 15, 1);
    checkCfg("R8 15-bit frame discarded", expCfg);
    sendFrame(16'h0002, 17, 1);
    checkCfg("R8 17-bit frame discarded", expCfg);
  endtask

  task automatic testUndefined();
    sendFrame(16'h0802, 16, 1);
    checkCfg("R9 address 00001 ignored", expCfg);
    sendFrame(16'hC003, 16, 1);
    checkCfg("R9 address 11000 ignored", expCfg);
    sendFrame(16'h8003, 16, 1);
    checkCfg("R9 fixed-level register ignored", expCfg);
  endtask

  task automatic testSoftReset();
    sendFrame(16'h4000, 16, 1);
    expCfg = DEF_CFG;
    checkCfg("R6 soft reset restores defaults", expCfg);
  endtask

  task automatic testHardReset();
    sendFrame(16'h0002, 16, 1);
    expCfg = 7'b0101000;
    checkCfg("R2 frame before hard reset", expCfg);
    @(negedge clk);
    rstN = 1'b0;
    waitClk(3);
    expCfg = DEF_CFG;
    checkCfg("R1 defaults while reset held", expCfg);
    rstN = 1'b1;
    waitClk(5);
    checkCfg("R1 defaults after reset release", expCfg);
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    testReset();
    testScan();
    testFormat();
    testDelay();
    testLatency();
    testStandby();
    testBadCount();
    testUndefined();
    testSoftReset();
    testHardReset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule